// File: doc/BRIEF.md
# SPI Fixed-Length Burst Chunker

This block is an SPI master front end for a slave whose registers are reached by address. A single request names a 5-bit block, a 16-bit start address, a byte count and a direction. The block cuts that transfer into frames that each carry 4, 2 or 1 data bytes. Each frame has its own address and its own control byte that states the frame length, so the slave can find every frame end without a chip select. Every frame is sent as two address bytes, one control byte and the data bytes. The address for the next frame moves forward by the number of bytes just sent.

Requests arrive through a valid/ready handshake, and `req_ready` is high only while the block is idle. Write bytes are pulled one at a time through a valid/ready input stream. If the source holds `wr_valid` low, the SPI bus stalls with SCLK low until the byte arrives, so no write byte is ever lost or invented. Read bytes come out in address order as one-cycle `rd_valid` strobes. The read stream has no ready signal, so the consumer must accept each strobe. A one-cycle `done` pulse marks the end of the transfer.

Top module: `spi_chunk_master`

## Requirements
- R1: `req_ready` is high only in the idle state. It stays low from the cycle after a request with a non-zero count is accepted until `done` is pulsed.
- R2: A request with a byte count of zero produces `done` in the cycle after it is accepted, and no SCLK edge.
- R3: Each frame is 24 + 8·n bits long, sent MSB first. The first 16 bits are the frame address, high byte first. The next 8 bits are the control byte. The last 8·n bits are the n data bytes.
- R4: The control byte is built as follows: bits 7:3 hold the block select, bit 2 is the direction (1 = write, 0 = read), and bits 1:0 hold the length code (01 = 1 byte, 10 = 2 bytes, 11 = 4 bytes).
- R5: Frame sizes are chosen greedily from the bytes still to send: 4 if at least 4 remain, else 2 if at least 2 remain, else 1. The length code is derived again for every frame, so 7 bytes give the codes 11, 10, 01.
- R6: Each frame after the first uses the previous frame address plus the previous frame size, wrapping modulo 2^16. For example, 7 bytes at address 23 give frames at addresses 23, 27 and 29.
- R7: The SPI timing is mode 0. SCLK idles low, and each SCLK high and low phase lasts `SCLK_DIV/2` system clocks. MOSI never changes while SCLK is high. MISO is sampled when SCLK rises.
- R8: Write bytes are taken only on `wr_valid && wr_ready`, one byte for each data byte sent, in stream order. `wr_ready` is never high together with `req_ready`. While `wr_ready` is high and `wr_valid` is low, SCLK stays low on the following cycle.
- R9: For a read, each data byte shifted in from MISO appears once on `rd_data` with a single-cycle `rd_valid`. Bytes appear in address order, `count` bytes in all.
- R10: `done` is a single-cycle pulse. It arrives after the last data bit of the last frame, while SCLK is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_blk | input | 5 | Block select for the control byte |
| req_addr | input | 16 | Start address |
| req_cnt | input | CNT_W | Number of data bytes |
| req_wr | input | 1 | 1 = write, 0 = read |
| wr_valid | input | 1 | Write byte valid |
| wr_ready | output | 1 | Block takes the write byte |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Transfer complete pulse |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | SPI data out |
| miso | input | 1 | SPI data in |

## Verification
Suppose the remaining count or the frame address is wrong inside the block. The fault shows at the ports in the next control or address byte on MOSI, within one frame time. A stale length code or a wrong chunk size also changes where the slave model decides a frame ends, so every later frame decodes wrongly and the read byte count or the `done` timing moves. A wrong shifter state breaks the SCLK phase length or the MOSI stability within one SCLK period. A wrong sequencer state shows as `req_ready` or `wr_ready` at the wrong time, or as a missing, repeated or widened `done`.

// File: rtl/spi_chunk_pkg.sv
package spi_chunk_pkg;
  localparam int ADDR_W = 16;
  localparam int BLK_W  = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_WAIT} seq_st_t;
  typedef enum logic {PH_HDR, PH_DATA} seq_ph_t;

  function automatic logic [1:0] len_code(input logic [2:0] nbytes);
    case (nbytes)
      3'd4:    len_code = 2'b11;
      3'd2:    len_code = 2'b10;
      3'd1:    len_code = 2'b01;
      default: len_code = 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/spi_chunk_calc.sv
module spi_chunk_calc #(
  parameter int CNT_W = 12
) (
  input  logic [CNT_W-1:0] remain,
  output logic [2:0]       size,
  output logic [1:0]       mode
);
  import spi_chunk_pkg::*;

  always_comb begin
    if (remain >= CNT_W'(4))      size = 3'd4;
    else if (remain >= CNT_W'(2)) size = 3'd2;
    else if (remain != '0)        size = 3'd1;
    else                          size = 3'd0;
    mode = len_code(size);
  end
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int SCLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  output logic       busy,
  output logic       byte_done,
  output logic [7:0] rx,
  output logic       sclk,
  output logic       mosi,
  input  logic       miso
);
  localparam int HALF = SCLK_DIV / 2;
  localparam int HW   = $clog2(HALF + 1);

  logic [7:0]    sh_q;
  logic [7:0]    rx_q;
  logic [HW-1:0] hc_q;
  logic [2:0]    bit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q      <= '0;
      rx_q      <= '0;
      hc_q      <= '0;
      bit_q     <= '0;
      busy      <= 1'b0;
      byte_done <= 1'b0;
      sclk      <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (!busy) begin
        if (start) begin
          sh_q  <= tx;
          busy  <= 1'b1;
          hc_q  <= '0;
          bit_q <= '0;
        end
      end else if (hc_q == HW'(HALF - 1)) begin
        hc_q <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          rx_q <= {rx_q[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bit_q == 3'd7) begin
            busy      <= 1'b0;
            byte_done <= 1'b1;
          end else begin
            bit_q <= bit_q + 3'd1;
            sh_q  <= {sh_q[6:0], 1'b0};
          end
        end
      end else begin
        hc_q <= hc_q + HW'(1);
      end
    end
  end

  assign mosi = sh_q[7];
  assign rx   = rx_q;
endmodule

// File: rtl/spi_chunk_master.sv
module spi_chunk_master #(
  parameter int CNT_W    = 12,
  parameter int SCLK_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [4:0]       req_blk,
  input  logic [15:0]      req_addr,
  input  logic [CNT_W-1:0] req_cnt,
  input  logic             req_wr,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso
);
  import spi_chunk_pkg::*;

  seq_st_t           st_q;
  seq_ph_t           ph_q;
  logic [BLK_W-1:0]  blk_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  rem_q;
  logic              wr_q;
  logic [1:0]        hidx_q;
  logic [1:0]        didx_q;
  logic              done_q;
  logic              rdv_q;
  logic [7:0]        rdd_q;

  logic [2:0] size;
  logic [1:0] mode;
  logic       sh_busy, sh_done, sh_start;
  logic [7:0] sh_rx, sh_tx, hdr_byte;

  spi_chunk_calc #(.CNT_W(CNT_W)) u_calc (
    .remain (rem_q),
    .size   (size),
    .mode   (mode)
  );

  spi_byte_shifter #(.SCLK_DIV(SCLK_DIV)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (sh_start),
    .tx        (sh_tx),
    .busy      (sh_busy),
    .byte_done (sh_done),
    .rx        (sh_rx),
    .sclk      (sclk),
    .mosi      (mosi),
    .miso      (miso)
  );

  always_comb begin
    case (hidx_q)
      2'd0:    hdr_byte = addr_q[15:8];
      2'd1:    hdr_byte = addr_q[7:0];
      default: hdr_byte = {blk_q, wr_q, mode};
    endcase
  end

  assign req_ready = (st_q == ST_IDLE);
  assign wr_ready  = (st_q == ST_LOAD) && (ph_q == PH_DATA) && wr_q && !sh_busy;
  assign sh_start  = (st_q == ST_LOAD) && !sh_busy &&
                     ((ph_q == PH_HDR) || !wr_q || wr_valid);
  assign sh_tx     = (ph_q == PH_HDR) ? hdr_byte : (wr_q ? wr_data : 8'h00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_HDR;
      blk_q  <= '0;
      addr_q <= '0;
      rem_q  <= '0;
      wr_q   <= 1'b0;
      hidx_q <= '0;
      didx_q <= '0;
      done_q <= 1'b0;
      rdv_q  <= 1'b0;
      rdd_q  <= '0;
    end else begin
      done_q <= 1'b0;
      rdv_q  <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            if (req_cnt == '0) begin
              done_q <= 1'b1;
            end else begin
              blk_q  <= req_blk;
              addr_q <= req_addr;
              rem_q  <= req_cnt;
              wr_q   <= req_wr;
              ph_q   <= PH_HDR;
              hidx_q <= '0;
              st_q   <= ST_LOAD;
            end
          end
        end
        ST_LOAD: begin
          if (sh_start) st_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (sh_done) begin
            st_q <= ST_LOAD;
            if (ph_q == PH_HDR) begin
              if (hidx_q == 2'd2) begin
                ph_q   <= PH_DATA;
                didx_q <= '0;
              end else begin
                hidx_q <= hidx_q + 2'd1;
              end
            end else begin
              if (!wr_q) begin
                rdv_q <= 1'b1;
                rdd_q <= sh_rx;
              end
              if ({1'b0, didx_q} == 3'(size - 3'd1)) begin
                addr_q <= addr_q + ADDR_W'(size);
                rem_q  <= rem_q - CNT_W'(size);
                ph_q   <= PH_HDR;
                hidx_q <= '0;
                if (rem_q == CNT_W'(size)) begin
                  st_q   <= ST_IDLE;
                  done_q <= 1'b1;
                end
              end else begin
                didx_q <= didx_q + 2'd1;
              end
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done     = done_q;
  assign rd_valid = rdv_q;
  assign rd_data  = rdd_q;
endmodule

// File: rtl/spi_chunk_master_chk.sv
module spi_chunk_master_chk #(
  parameter int CNT_W    = 12,
  parameter int SCLK_DIV = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [CNT_W-1:0] req_cnt,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             rd_valid,
  input logic             done,
  input logic             sclk,
  input logic             mosi
);
  localparam int HALF = SCLK_DIV / 2;
  localparam int CW   = $clog2(HALF + 2) + 1;

  logic [CW-1:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)    hi_cnt <= '0;
    else if (sclk) hi_cnt <= hi_cnt + CW'(1);
    else           hi_cnt <= '0;
  end

  p_busy_no_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !req_ready);

  p_zero_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_cnt == '0) |=> (done && !sclk));

  p_mosi_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  p_high_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (hi_cnt == CW'(HALF)));

  p_stall_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready && !wr_valid) |=> !sclk);

  p_ready_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> !req_ready);

  p_rd_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!sclk && req_ready));
endmodule

bind spi_chunk_master spi_chunk_master_chk #(.CNT_W(CNT_W), .SCLK_DIV(SCLK_DIV)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_cnt   (req_cnt),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .rd_valid  (rd_valid),
  .done      (done),
  .sclk      (sclk),
  .mosi      (mosi)
);

// File: tb/sim_spi_chunk_master.sv
`timescale 1ns/1ps
module sim_spi_chunk_master;
  localparam int CNT_W = 12;
  localparam int DIV   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [4:0] req_blk = '0;
  logic [15:0] req_addr = '0;
  logic [CNT_W-1:0] req_cnt = '0;
  logic req_wr = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [7:0] wr_data = '0;
  logic rd_valid;
  logic [7:0] rd_data;
  logic done;
  logic sclk, mosi;
  logic miso = 1'b0;

  always #2 clk = ~clk;

  spi_chunk_master #(.CNT_W(CNT_W), .SCLK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_blk(req_blk), .req_addr(req_addr), .req_cnt(req_cnt), .req_wr(req_wr),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  int total = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] slave_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // slave frame monitor
  logic [15:0] f_addr [0:31];
  logic [7:0]  f_ctrl [0:31];
  logic [7:0]  f_dat  [0:31][0:3];
  int          f_len  [0:31];
  int          nfr = 0;
  logic [63:0] msh = '0;
  logic [23:0] fhdr = '0;
  int          bc = 0;
  int          flen = 0;

  always @(posedge sclk) begin
    msh = {msh[62:0], mosi};
    bc++;
    if (bc == 24) begin
      fhdr = msh[23:0];
      case (msh[1:0])
        2'b01:   flen = 1;
        2'b10:   flen = 2;
        2'b11:   flen = 4;
        default: flen = 0;
      endcase
    end
    if (bc >= 24 && bc == 24 + 8 * flen) begin
      if (nfr < 32) begin
        f_addr[nfr] = fhdr[23:8];
        f_ctrl[nfr] = fhdr[7:0];
        f_len[nfr]  = flen;
        for (int k = 0; k < flen; k++) f_dat[nfr][k] = 8'(msh >> (8 * (flen - 1 - k)));
        nfr++;
      end
      bc = 0;
    end
  end

  always @(negedge sclk) begin
    if (bc >= 24 && bc < 24 + 8 * flen && !fhdr[2]) begin
      logic [7:0] v;
      int idx;
      idx = bc - 24;
      v = slave_byte(fhdr[23:8] + 16'(idx / 8));
      miso = v[7 - (idx % 8)];
    end else begin
      miso = 1'b0;
    end
  end

  // cycle monitors
  int   viol_hi = 0, viol_mosi = 0, done_cnt = 0, done_wide = 0, hi_run = 0;
  logic prev_sclk = 1'b0, prev_mosi = 1'b0, prev_done = 1'b0;
  logic [7:0] rd_buf [0:63];
  int   rd_n = 0;
  int   wr_idx = 0;
  int   cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (sclk) hi_run++;
    else if (prev_sclk) begin
      if (hi_run != DIV / 2) viol_hi++;
      hi_run = 0;
    end
    if (sclk && prev_sclk && mosi != prev_mosi) viol_mosi++;
    if (done) done_cnt++;
    if (done && prev_done) done_wide++;
    if (rd_valid && rd_n < 64) begin rd_buf[rd_n] = rd_data; rd_n++; end
    if (wr_valid && wr_ready) wr_idx++;
    prev_sclk = sclk; prev_mosi = mosi; prev_done = done;
  end

  // write stream source with stalls
  logic [7:0] wr_buf [0:63];
  int  wr_n = 0;
  bit  feed_en = 1'b0;
  always @(negedge clk) begin
    wr_valid = feed_en && (wr_idx < wr_n) && ((cyc % 3) != 0);
    wr_data  = (wr_idx < 64) ? wr_buf[wr_idx] : 8'h00;
  end

  task automatic clear_mon();
    nfr = 0; bc = 0; flen = 0; rd_n = 0; wr_idx = 0;
    done_cnt = 0; done_wide = 0; viol_hi = 0; viol_mosi = 0;
  endtask

  task automatic run_xfer(input logic [4:0] blk, input logic [15:0] addr,
                          input int cnt, input bit wr, input string tag);
    int n, busy_rdy, rem, fi, bi, sz;
    logic [15:0] ea;
    logic [1:0] code;
    @(negedge clk);
    clear_mon();
    for (int i = 0; i < 64; i++) wr_buf[i] = 8'(8'h31 + i * 13) ^ {3'b0, blk};
    wr_n = wr ? cnt : 0;
    feed_en = wr;
    req_blk = blk; req_addr = addr; req_cnt = CNT_W'(cnt); req_wr = wr;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0; busy_rdy = 0;
    while (!done && n < 20000) begin
      if (sclk && req_ready) busy_rdy++;
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, "R10", {tag, " done seen"}, done, 1);
    chk(bc == 0 && sclk == 1'b0, "R10", {tag, " done after last bit"}, bc, 0);
    repeat (6) @(negedge clk);
    feed_en = 1'b0;
    chk(done_cnt == 1 && done_wide == 0, "R10", {tag, " single done pulse"}, done_cnt, 1);
    chk(busy_rdy == 0, "R1", {tag, " req_ready low while busy"}, busy_rdy, 0);
    chk(viol_hi == 0 && viol_mosi == 0, "R7", {tag, " sclk phase / mosi stability"},
        viol_hi + viol_mosi, 0);
    // expected frames
    rem = cnt; ea = addr; fi = 0; bi = 0;
    while (rem > 0) begin
      sz = (rem >= 4) ? 4 : (rem >= 2) ? 2 : 1;
      code = (sz == 4) ? 2'b11 : (sz == 2) ? 2'b10 : 2'b01;
      if (fi < nfr) begin
        chk(f_addr[fi] == ea, "R3 R6", $sformatf("%s frame %0d address", tag, fi), f_addr[fi], ea);
        chk(f_ctrl[fi] == {blk, wr, code}, "R4 R5", $sformatf("%s frame %0d control", tag, fi),
            f_ctrl[fi], {blk, wr, code});
        if (wr)
          for (int k = 0; k < sz; k++)
            chk(f_dat[fi][k] == wr_buf[bi + k], "R8",
                $sformatf("%s frame %0d data %0d", tag, fi, k), f_dat[fi][k], wr_buf[bi + k]);
      end
      fi++; bi += sz; rem -= sz; ea = ea + 16'(sz);
    end
    chk(nfr == fi, "R5", {tag, " frame count"}, nfr, fi);
    if (wr) begin
      chk(wr_idx == cnt, "R8", {tag, " write bytes consumed"}, wr_idx, cnt);
      chk(rd_n == 0, "R9", {tag, " no read strobes on write"}, rd_n, 0);
    end else begin
      chk(rd_n == cnt, "R9", {tag, " read byte count"}, rd_n, cnt);
      for (int i = 0; i < cnt && i < rd_n; i++)
        chk(rd_buf[i] == slave_byte(addr + 16'(i)), "R9",
            $sformatf("%s read byte %0d", tag, i), rd_buf[i], slave_byte(addr + 16'(i)));
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "reset req_ready", req_ready, 1);
    chk(done == 1'b0 && rd_valid == 1'b0, "R10", "reset done/rd_valid", {done, rd_valid}, 0);
    chk(sclk == 1'b0 && wr_ready == 1'b0, "R7", "reset sclk/wr_ready", {sclk, wr_ready}, 0);
  endtask

  task automatic t_zero();
    @(negedge clk);
    clear_mon();
    req_blk = 5'd3; req_addr = 16'h0100; req_cnt = '0; req_wr = 1'b1;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(done == 1'b1, "R2", "zero count done next cycle", done, 1);
    repeat (4 * DIV) @(negedge clk);
    chk(nfr == 0 && bc == 0, "R2", "zero count no bus activity", bc + nfr, 0);
    chk(done_cnt == 1, "R2", "zero count one done", done_cnt, 1);
  endtask

  task automatic t_write7();  run_xfer(5'd5,  16'd23,   7, 1'b1, "write7");  endtask
  task automatic t_read5();   run_xfer(5'd18, 16'hFFFE, 5, 1'b0, "read5_wrap"); endtask
  task automatic t_write1();  run_xfer(5'd31, 16'h1234, 1, 1'b1, "write1");  endtask
  task automatic t_read2();   run_xfer(5'd1,  16'h00F0, 2, 1'b0, "read2");   endtask
  task automatic t_write11(); run_xfer(5'd9,  16'h7FFC, 11, 1'b1, "write11"); endtask

  bit finished = 1'b0;

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_zero();
    t_write7();
    t_read5();
    t_write1();
    t_read2();
    t_write11();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule